// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block is a pulse-width modulator that sits on a simple 32-bit register bus. Software sets a clock divider and a period length, then streams duty values into a four-deep queue. The block divides the system clock by the programmed ratio to get a count tick. It counts each period in those ticks. At every period boundary it takes the next queued duty value. The output stays high for that many ticks and low for the rest of the period. Software can pace its writes against the queue occupancy shown in the status register, so the waveform changes smoothly from one period to the next without glitches.

A self-clearing soft reset returns every piece of state to zero, including the queue. Software starts it with a single control write and polls the busy bit until it drops. Reads are combinational from the address. Writes take effect on the clock edge on which the write strobe is sampled.

Top module: `pwmq_top`

## Requirements
- R1: Register map: control at 0x00 (bit 0 run enable, bit 3 soft-reset busy, bits 15:4 divider field), status at 0x04 (bits 2:0 queue occupancy), sample at 0x0C, period at 0x10 (bits 15:0). Bits not listed read as 0. After reset every register reads 0 and the output is low.
- R2: With divider field D, one count tick lasts D+1 clock cycles, so every high and low time scales by D+1.
- R3: With stored period value P, a period lasts min(P, 0xFFFE)+2 ticks. The period register reads back the value as written.
- R4: With duty value W, the output is high for the first W ticks of each period and low for the rest. W = 0 gives a constant low output, and W at or above the period length gives a constant high output.
- R5: A write to the sample address appends the low 16 bits to a 4-entry queue. The status occupancy tracks the number of stored entries, from 0 to 4.
- R6: A write to the sample address while the queue holds 4 entries, with no removal in that cycle, is discarded. The stored entries and their order stay unchanged.
- R7: The duty value in use changes only at a period boundary or at the start of a run. When the queue is empty at that point, the previous duty value is reused. A read of the sample address returns the duty value in use.
- R8: While the enable bit is 0, the output is low and the tick and period counters stay at zero. After enable is written to 1, the block takes a queued value on the next clock edge and starts a fresh period from count zero.
- R9: Writing a control word with bit 3 set clears enable, divider, period, duty in use and queue on that same edge. Bit 3 then reads 1 for exactly SWR_CYCLES clock cycles and 0 afterwards. Bus writes made while bit 3 reads 1 are ignored.
- R10: When a sample write and a removal from a full queue fall on the same edge, the write is accepted. Occupancy stays at 4, and the new value is used after the older entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 1 | Modulated output |

## Verification
Two events can land on the same edge: a removal from the queue, at the start of a run or at a period boundary, and a sample write from the bus. The bench fills the queue to four entries while the block is idle. It then issues the enable write and a sample write on back-to-back edges, so the start-of-run removal meets the push. It judges the outcome in two ways: the occupancy must still read 4 right afterwards, and the successive high times must show the four old values followed by the new one. A separate case without a removal checks that the write is discarded, because the last old value then repeats in place of the written one.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;

    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 32;
    localparam int DIV_W    = 12;
    localparam int SPAN_W   = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_SAMPLE = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_SPAN   = 5'h10;

    localparam int BIT_RUN   = 0;
    localparam int BIT_SOFT  = 3;
    localparam int DIV_LSB   = 4;

    localparam logic [SPAN_W-1:0] SPAN_CAP = 16'hFFFE;

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    function automatic logic [SPAN_W-1:0] clamp_span(input logic [SPAN_W-1:0] raw);
        return (raw >= SPAN_CAP) ? SPAN_CAP : raw;
    endfunction

endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs
    import pwmq_pkg::*;
#(
    parameter int SWR_CYCLES = 4,
    parameter int OCC_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [OCC_W-1:0]  occupancy,
    input  logic [SPAN_W-1:0] duty_now,
    output ctrl_t             ctrl,
    output logic [SPAN_W-1:0] span_raw,
    output logic              push,
    output logic [SPAN_W-1:0] push_data,
    output logic              soft_clr,
    output logic              soft_busy,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int SWR_W = $clog2(SWR_CYCLES + 1);

    logic [SWR_W-1:0] soft_cnt;
    logic             soft_start;
    logic             wr_ok;
    logic             unused_wbits;

    assign soft_busy  = (soft_cnt != '0);
    assign soft_start = bus_wr && !soft_busy && (bus_addr == OFS_CTRL) && bus_wdata[BIT_SOFT];
    assign soft_clr   = soft_start || soft_busy;
    assign wr_ok      = bus_wr && !soft_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_cnt <= '0;
        end else if (soft_start) begin
            soft_cnt <= SWR_W'(SWR_CYCLES);
        end else if (soft_busy) begin
            soft_cnt <= soft_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            ctrl     <= '0;
            span_raw <= '0;
        end else if (wr_ok) begin
            if (bus_addr == OFS_CTRL) begin
                ctrl.run <= bus_wdata[BIT_RUN];
                ctrl.div <= bus_wdata[DIV_LSB +: DIV_W];
            end
            if (bus_addr == OFS_SPAN) begin
                span_raw <= bus_wdata[SPAN_W-1:0];
            end
        end
    end

    assign push      = wr_ok && (bus_addr == OFS_SAMPLE);
    assign push_data = bus_wdata[SPAN_W-1:0];

    assign unused_wbits = ^{bus_wdata[DATA_W-1:DIV_LSB+DIV_W], bus_wdata[2:1]};

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[BIT_RUN]               = ctrl.run;
                bus_rdata[BIT_SOFT]              = soft_busy;
                bus_rdata[DIV_LSB +: DIV_W]      = ctrl.div;
            end
            OFS_STAT:   bus_rdata[OCC_W-1:0]  = occupancy;
            OFS_SAMPLE: bus_rdata[SPAN_W-1:0] = duty_now;
            OFS_SPAN:   bus_rdata[SPAN_W-1:0] = span_raw;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwmq_fifo.sv
module pwmq_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             full, take, give;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign give  = pop && !empty;
    assign take  = push && (!full || give);
    assign head  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (take) begin
            store[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (take) wr_ptr <= bump(wr_ptr);
            if (give) rd_ptr <= bump(rd_ptr);
            case ({take, give})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/pwmq_timebase.sv
module pwmq_timebase
    import pwmq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [SPAN_W-1:0] span_raw,
    input  logic              q_empty,
    input  logic [SPAN_W-1:0] q_head,
    output logic              pop,
    output logic              load,
    output logic              running,
    output logic [SPAN_W-1:0] span_cnt,
    output logic [SPAN_W-1:0] duty,
    output logic              wave
);
    logic [DIV_W-1:0]  tick_cnt;
    logic [SPAN_W-1:0] last_cnt;
    logic              tick, wrap;

    assign last_cnt = clamp_span(span_raw) + 1'b1;
    assign tick     = (tick_cnt == ctrl.div);
    assign wrap     = running && tick && (span_cnt >= last_cnt);
    assign load     = ctrl.run && (!running || wrap);
    assign pop      = load && !q_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            tick_cnt <= '0;
            span_cnt <= '0;
            duty     <= '0;
        end else begin
            if (!ctrl.run) begin
                running  <= 1'b0;
                tick_cnt <= '0;
                span_cnt <= '0;
            end else if (!running) begin
                running  <= 1'b1;
            end else begin
                tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
                if (tick) begin
                    span_cnt <= wrap ? '0 : span_cnt + 1'b1;
                end
            end
            if (pop) begin
                duty <= q_head;
            end
        end
    end

    assign wave = ctrl.run && running && (span_cnt < duty);

endmodule

// File: rtl/pwmq_top.sv
module pwmq_top
    import pwmq_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int SWR_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);
    localparam int OCC_W = $clog2(FIFO_DEPTH + 1);

    ctrl_t             ctrl;
    logic [SPAN_W-1:0] span_raw, push_data, q_head, duty, span_cnt;
    logic [OCC_W-1:0]  occupancy;
    logic              push, pop, load, q_empty, running;
    logic              soft_clr, soft_busy, core_rst, run_en;

    assign core_rst = rst || soft_clr;
    assign run_en   = ctrl.run;

    pwmq_regs #(.SWR_CYCLES(SWR_CYCLES), .OCC_W(OCC_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .occupancy(occupancy), .duty_now(duty),
        .ctrl(ctrl), .span_raw(span_raw), .push(push), .push_data(push_data),
        .soft_clr(soft_clr), .soft_busy(soft_busy), .bus_rdata(bus_rdata)
    );

    pwmq_fifo #(.DEPTH(FIFO_DEPTH), .W(SPAN_W)) u_fifo (
        .clk(clk), .rst(core_rst), .push(push), .wdata(push_data),
        .pop(pop), .head(q_head), .empty(q_empty), .count(occupancy)
    );

    pwmq_timebase u_time (
        .clk(clk), .rst(core_rst), .ctrl(ctrl), .span_raw(span_raw),
        .q_empty(q_empty), .q_head(q_head), .pop(pop), .load(load),
        .running(running), .span_cnt(span_cnt), .duty(duty), .wave(pwm_out)
    );

endmodule

// File: rtl/pwmq_checker.sv
module pwmq_checker #(
    parameter int DEPTH = 4,
    parameter int OCC_W = 3,
    parameter int DW    = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic             pwm_out,
    input logic [OCC_W-1:0] occupancy,
    input logic             push,
    input logic             pop,
    input logic             load,
    input logic             soft_clr,
    input logic             soft_busy,
    input logic [DW-1:0]    duty,
    input logic [DW-1:0]    span_cnt
);

    assert_occ_bound_R5: assert property (@(posedge clk) disable iff (rst)
        occupancy <= OCC_W'(DEPTH));

    assert_full_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (occupancy == OCC_W'(DEPTH) && push) |=> (occupancy == OCC_W'(DEPTH)));

    assert_duty_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && !soft_clr) |=> $stable(duty));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (span_cnt == '0));

    assert_soft_clear_R9: assert property (@(posedge clk) disable iff (rst)
        soft_busy |-> (occupancy == '0 && !pwm_out && !run_en && duty == '0));

    assert_pop_needs_run_R8: assert property (@(posedge clk) disable iff (rst)
        pop |-> run_en);

endmodule

bind pwmq_top pwmq_checker #(.DEPTH(FIFO_DEPTH), .OCC_W(OCC_W), .DW(pwmq_pkg::SPAN_W)) u_chk (
    .clk(clk), .rst(rst), .run_en(run_en), .pwm_out(pwm_out),
    .occupancy(occupancy), .push(push), .pop(pop), .load(load),
    .soft_clr(soft_clr), .soft_busy(soft_busy), .duty(duty), .span_cnt(span_cnt)
);

// File: tb/tb_pwmq_top.sv
module tb_pwmq_top;
    localparam int SWR_CYCLES = 4;
    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SMPL = 5'h0C, A_SPAN = 5'h10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwmq_top #(.FIFO_DEPTH(4), .SWR_CYCLES(SWR_CYCLES)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic check_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next rising edge.
    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic soft_reset();
        do_write(A_CTRL, 32'h8);
        repeat (SWR_CYCLES + 1) @(negedge clk);
    endtask

    task automatic next_high(output int len);
        while (!pwm_out) @(negedge clk);
        len = 0;
        while (pwm_out) begin len++; @(negedge clk); end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_read(A_CTRL, v);   check_eq("R1 ctrl reset", v, 0);
        do_read(A_STAT, v);   check_eq("R1 status reset", v, 0);
        do_read(A_SMPL, v);   check_eq("R1 sample reset", v, 0);
        do_read(A_SPAN, v);   check_eq("R1 period reset", v, 0);
        check_eq("R1 output reset", pwm_out, 0);
        do_write(A_CTRL, 32'hFFFF_FFF7);
        do_read(A_CTRL, v);   check_eq("R1 ctrl unused bits", v, 32'h0000_FFF1);
        do_write(A_CTRL, 32'h0);
        do_write(A_SPAN, 32'h1234_ABCD);
        do_read(A_SPAN, v);   check_eq("R1 R3 period readback", v, 32'h0000_ABCD);
    endtask

    task automatic t_wave(input string tag, input int div, input int span, input int w);
        int len, hi, lo, tk;
        soft_reset();
        len = ((span >= 32'hFFFE) ? 32'hFFFE : span) + 2;
        tk  = div + 1;
        do_write(A_SMPL, w);
        do_write(A_SPAN, span);
        do_write(A_CTRL, (div << 4) | 1);
        check_eq({tag, " R8 low before start"}, pwm_out, 0);
        next_high(hi);
        lo = 0;
        while (!pwm_out) begin lo++; @(negedge clk); end
        check_eq({tag, " R4 R8 high time"}, hi, w * tk);
        check_eq({tag, " R2 R3 low time"}, lo, (len - w) * tk);
        do_write(A_CTRL, 0);
        check_eq({tag, " R8 low after disable"}, pwm_out, 0);
        hi = 0;
        repeat (10) begin @(negedge clk); hi += pwm_out; end
        check_eq({tag, " R8 stays low"}, hi, 0);
    endtask

    task automatic t_const(input string tag, input int w, input int exp_all_high);
        int hi;
        soft_reset();
        do_write(A_SMPL, w);
        do_write(A_SPAN, 2);
        do_write(A_CTRL, 1);
        @(negedge clk);
        hi = 0;
        repeat (24) begin hi += pwm_out; @(negedge clk); end
        check_eq({tag, " R4 constant level"}, hi, exp_all_high ? 24 : 0);
        do_write(A_CTRL, 0);
    endtask

    task automatic t_boundary();
        logic [31:0] v;
        int hi;
        soft_reset();
        do_write(A_SMPL, 2);
        do_write(A_SPAN, 6);
        do_write(A_CTRL, 1);
        do_write(A_SMPL, 5);
        do_read(A_SMPL, v);  check_eq("R7 duty held mid-period", v, 2);
        do_read(A_STAT, v);  check_eq("R5 one queued", v, 1);
        while (pwm_out) @(negedge clk);
        next_high(hi);       check_eq("R7 new duty after boundary", hi, 5);
        next_high(hi);       check_eq("R7 empty queue repeats", hi, 5);
        do_read(A_SMPL, v);  check_eq("R7 sample reads duty in use", v, 5);
        do_write(A_CTRL, 0);
    endtask

    task automatic t_full_drop();
        logic [31:0] v;
        int hi;
        int exp [5] = '{1, 2, 3, 4, 4};
        soft_reset();
        for (int i = 1; i <= 4; i++) begin
            do_write(A_SMPL, i);
            do_read(A_STAT, v);  check_eq("R5 occupancy", v, i);
        end
        do_write(A_SMPL, 7);
        do_read(A_STAT, v);  check_eq("R6 full write dropped", v, 4);
        do_write(A_SPAN, 6);
        do_write(A_CTRL, 1);
        for (int i = 0; i < 5; i++) begin
            next_high(hi);   check_eq("R6 R7 queued order", hi, exp[i]);
        end
        do_read(A_STAT, v);  check_eq("R5 drained", v, 0);
        do_write(A_CTRL, 0);
    endtask

    task automatic t_push_pop();
        logic [31:0] v;
        int hi;
        int exp [6] = '{1, 2, 3, 4, 6, 6};
        soft_reset();
        for (int i = 1; i <= 4; i++) do_write(A_SMPL, i);
        do_write(A_SPAN, 6);
        do_write(A_CTRL, 1);
        do_write(A_SMPL, 6);
        do_read(A_STAT, v);  check_eq("R10 push with pop keeps full", v, 4);
        for (int i = 0; i < 6; i++) begin
            next_high(hi);   check_eq("R10 order after concurrent push", hi, exp[i]);
        end
        do_write(A_CTRL, 0);
    endtask

    task automatic t_soft();
        logic [31:0] v;
        soft_reset();
        do_write(A_SMPL, 3);
        do_write(A_SMPL, 4);
        do_write(A_SPAN, 9);
        do_write(A_CTRL, (5 << 4) | 1);
        repeat (30) @(negedge clk);
        do_write(A_CTRL, 32'h9);
        do_read(A_CTRL, v);  check_eq("R9 busy set, enable cleared", v, 32'h8);
        do_read(A_STAT, v);  check_eq("R9 queue flushed", v, 0);
        do_read(A_SMPL, v);  check_eq("R9 duty cleared", v, 0);
        check_eq("R9 output low", pwm_out, 0);
        do_write(A_SPAN, 5);
        do_read(A_SPAN, v);  check_eq("R9 write while busy ignored", v, 0);
        @(negedge clk);
        do_read(A_CTRL, v);  check_eq("R9 busy cycle 3", v, 32'h8);
        @(negedge clk);
        do_read(A_CTRL, v);  check_eq("R9 busy cycle 4", v, 32'h8);
        @(negedge clk);
        do_read(A_CTRL, v);  check_eq("R9 busy self-clears", v, 0);
        do_write(A_SPAN, 5);
        do_read(A_SPAN, v);  check_eq("R9 writes accepted after", v, 5);
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wave("basic",   0, 6, 3);
        t_wave("divided", 2, 4, 2);
        t_wave("mixed",   1, 10, 5);
        t_wave("capped",  0, 32'hFFFF, 32'hFFFE);
        t_const("zero duty", 0, 0);
        t_const("full duty", 4, 1);
        t_const("over duty", 9, 1);
        t_boundary();
        t_full_drop();
        t_push_pop();
        t_soft();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule